// File: doc/BRIEF.md
# Mailbox Command Transaction Sequencer

This block is a bus master that carries out one full request and response exchange with a word-addressed mailbox register window. A local client hands it a command header and a count of argument words. The sequencer then feeds the command words into the mailbox's command FIFO. Before each word it reads back the FIFO's free-space count. After each word it waits a fixed settle time, because the mailbox needs that long to refresh the count.

Once the last command word is written, the sequencer polls the interrupt status register until its ready bit is set. It then reads the response status word, which carries a start-of-packet flag, an end-of-packet flag and the fill level. With these it paces the reads of the response header and of each data word. If the header carries a nonzero error code, the data phase is skipped. Otherwise each data word is passed on over a valid/last stream. A one-cycle completion pulse reports the error code, the number of data words delivered and whether a poll limit ran out. Only one transaction is in flight at a time.

Mailbox register offsets used: 0 command word, 1 command last word, 2 command free space, 5 response data, 6 response status, 8 interrupt status. The bus has one cycle of read latency: the read data for a read issued in one cycle is valid in the next cycle.

Top module: `mbx_txn_seq`

## Requirements
- R1: No command write (offset 0 or 1) occurs unless the most recent read of offset 2 since the previous write returned a nonzero value; while free space reads zero, no command word is written.
- R2: At least SETTLE_CYC (default 3) full clock cycles separate a command write from the next read of offset 2.
- R3: The header and then the arguments, in order, are written one word per write. Every word except the final one goes to offset 0 and the final word goes to offset 1. A request with zero arguments produces exactly one write: its header, to offset 1.
- R4: After the last command write, offset 8 is read until bit 0 reads 1, and neither offset 5 nor offset 6 is read before that.
- R5: Response status at offset 6 has SOP in bit 0, EOP in bit 1 and the fill level in bits 12:2. The header is read from offset 5 only after a status read with SOP=1 and a nonzero fill level.
- R6: The response header holds the error code in bits 10:0 and LENGTH (number of data words after the header) in bits 22:12. A nonzero error code ends the transaction with that code, no further offset-5 reads and no result words.
- R7: Each data word is read only after a status read with a nonzero fill level, and the final word only after one with EOP=1 and fill level exactly 1. Data words leave on res_data in arrival order with res_valid, and res_last is set on the final word only.
- R8: req_ready is high only while idle; from acceptance until completion busy is high and req_ready is low.
- R9: done is a single-cycle pulse that carries done_err, done_count (the number of data words delivered) and done_timeout.
- R10: POLL_LIMIT consecutive unsuccessful polls in any wait end the transaction with done_timeout=1 and no further bus access.
- R11: After reset the block is idle: busy=0, req_ready=1, and no bus access, result or done output is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_header | input | 32 | Command header word |
| req_argc | input | ARGC_W | Number of argument words (0 to 15) |
| arg_valid | input | 1 | Argument word offered |
| arg_ready | output | 1 | Argument word taken this cycle when valid |
| arg_data | input | 32 | Argument word |
| bus_addr | output | 4 | Mailbox word offset |
| bus_write | output | 1 | Write strobe |
| bus_wdata | output | 32 | Write data |
| bus_read | output | 1 | Read strobe |
| bus_rdata | input | 32 | Read data, valid the cycle after bus_read |
| res_valid | output | 1 | Response data word valid |
| res_data | output | 32 | Response data word |
| res_last | output | 1 | Final data word of the response |
| done | output | 1 | Transaction complete pulse |
| done_err | output | 11 | Error code from the response header |
| done_count | output | 11 | Data words delivered |
| done_timeout | output | 1 | Transaction aborted by the poll limit |
| busy | output | 1 | Transaction in progress |

## Verification
A request is accepted on the edge where req_valid meets req_ready. The first free-space read follows in the next cycle, and each poll takes two cycles: a read and then a check of the returned word. A command write comes one cycle after a nonzero free-space reply. The next free-space read comes no earlier than SETTLE_CYC cycles after the write. Each result word appears in the cycle after its offset-5 read, and done follows one cycle after the final word or after the header on an error.

The bench model of the mailbox logs every bus access at the clock edge with its cycle number. The bench samples outputs on the falling edge. It then checks the order of accesses and the gaps between them against these counts, not against fixed delays, and confirms that done drops on the cycle after it rises.

// File: rtl/mbx_seq_pkg.sv
package mbx_seq_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned ERR_W  = 11;
  localparam int unsigned LEN_W  = 11;
  localparam int unsigned FILL_W = 11;
  localparam int unsigned OFS_W  = 4;

  localparam logic [OFS_W-1:0] OFS_CMD  = 4'd0;
  localparam logic [OFS_W-1:0] OFS_LAST = 4'd1;
  localparam logic [OFS_W-1:0] OFS_FREE = 4'd2;
  localparam logic [OFS_W-1:0] OFS_RSP  = 4'd5;
  localparam logic [OFS_W-1:0] OFS_STAT = 4'd6;
  localparam logic [OFS_W-1:0] OFS_IRQ  = 4'd8;

  typedef enum logic [3:0] {
    S_IDLE, S_FREE_RD, S_FREE_CHK, S_CMD_WR, S_SETTLE,
    S_IRQ_RD, S_IRQ_CHK, S_STAT_RD, S_STAT_CHK,
    S_RSP_RD, S_RSP_CHK, S_DONE
  } seq_state_t;

  function automatic logic [ERR_W-1:0] hdr_err(input logic [WORD_W-1:0] w);
    return w[ERR_W-1:0];
  endfunction

  function automatic logic [LEN_W-1:0] hdr_len(input logic [WORD_W-1:0] w);
    return w[12 +: LEN_W];
  endfunction

  function automatic logic stat_sop(input logic [WORD_W-1:0] w);
    return w[0];
  endfunction

  function automatic logic stat_eop(input logic [WORD_W-1:0] w);
    return w[1];
  endfunction

  function automatic logic [FILL_W-1:0] stat_fill(input logic [WORD_W-1:0] w);
    return w[2 +: FILL_W];
  endfunction

  // Decide whether a status word allows the next offset-5 read.
  function automatic logic stat_ready(input logic [WORD_W-1:0] w,
                                      input logic hdr_phase,
                                      input logic final_word);
    logic nz;
    nz = (stat_fill(w) != '0);
    if (hdr_phase)       return nz && stat_sop(w);
    else if (final_word) return stat_eop(w) && (stat_fill(w) == FILL_W'(1));
    else                 return nz;
  endfunction

endpackage

// File: rtl/mbx_poll_guard.sv
module mbx_poll_guard #(
  parameter int unsigned LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic miss,
  output logic expired
);
  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [CW-1:0] miss_cnt;

  assign expired = miss && (miss_cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)                miss_cnt <= '0;
    else if (clear || expired) miss_cnt <= '0;
    else if (miss)             miss_cnt <= miss_cnt + 1'b1;
  end

  // R10
  guard_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss_cnt < CW'(LIMIT));

endmodule

// File: rtl/mbx_settle_timer.sv
module mbx_settle_timer #(
  parameter int unsigned CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic zero
);
  localparam int unsigned CW = $clog2(CYC + 1);

  logic [CW-1:0] remain;

  assign zero = (remain == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)            remain <= '0;
    else if (load)         remain <= CW'(CYC - 1);
    else if (run && !zero) remain <= remain - 1'b1;
  end

endmodule

// File: rtl/mbx_txn_seq.sv
module mbx_txn_seq
  import mbx_seq_pkg::*;
#(
  parameter int unsigned ARGC_W     = 4,
  parameter int unsigned POLL_LIMIT = 1000,
  parameter int unsigned SETTLE_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [31:0]       req_header,
  input  logic [ARGC_W-1:0] req_argc,
  input  logic              arg_valid,
  output logic              arg_ready,
  input  logic [31:0]       arg_data,
  output logic [3:0]        bus_addr,
  output logic              bus_write,
  output logic [31:0]       bus_wdata,
  output logic              bus_read,
  input  logic [31:0]       bus_rdata,
  output logic              res_valid,
  output logic [31:0]       res_data,
  output logic              res_last,
  output logic              done,
  output logic [10:0]       done_err,
  output logic [10:0]       done_count,
  output logic              done_timeout,
  output logic              busy
);
  localparam int unsigned WL_W = ARGC_W + 1;

  seq_state_t        state;
  logic [WORD_W-1:0] hdr_q;
  logic [WL_W-1:0]   words_left;
  logic              hdr_sent;
  logic              in_hdr;
  logic [LEN_W-1:0]  rsp_left;
  logic [ERR_W-1:0]  err_q;
  logic [LEN_W-1:0]  cnt_q;
  logic              tmo_q;

  // Named internal events
  logic accept, cmd_have, last_word, free_ok, irq_ok, stat_ok;
  logic poll_miss, poll_clear, poll_expired, settle_zero, settle_load;

  assign accept     = (state == S_IDLE) && req_valid;
  assign cmd_have   = !hdr_sent || arg_valid;
  assign last_word  = (words_left == WL_W'(1));
  assign free_ok    = (state == S_FREE_CHK) && (bus_rdata != '0);
  assign irq_ok     = (state == S_IRQ_CHK) && bus_rdata[0];
  assign stat_ok    = (state == S_STAT_CHK) &&
                      stat_ready(bus_rdata, in_hdr, rsp_left == LEN_W'(1));
  assign poll_miss  = ((state == S_FREE_CHK) && !free_ok) ||
                      ((state == S_IRQ_CHK)  && !irq_ok)  ||
                      ((state == S_STAT_CHK) && !stat_ok);
  assign poll_clear = accept || free_ok || irq_ok || stat_ok;
  assign settle_load = (state == S_CMD_WR) && cmd_have && !last_word;

  mbx_poll_guard #(.LIMIT(POLL_LIMIT)) u_guard (
    .clk(clk), .rst_n(rst_n), .clear(poll_clear),
    .miss(poll_miss), .expired(poll_expired)
  );

  mbx_settle_timer #(.CYC(SETTLE_CYC)) u_settle (
    .clk(clk), .rst_n(rst_n), .load(settle_load),
    .run(state == S_SETTLE), .zero(settle_zero)
  );

  // Port side
  assign req_ready = (state == S_IDLE);
  assign busy      = (state != S_IDLE);
  assign arg_ready = (state == S_CMD_WR) && hdr_sent;
  assign bus_write = (state == S_CMD_WR) && cmd_have;
  assign bus_wdata = hdr_sent ? arg_data : hdr_q;
  assign bus_read  = (state == S_FREE_RD) || (state == S_IRQ_RD) ||
                     (state == S_STAT_RD) || (state == S_RSP_RD);

  always_comb begin
    case (state)
      S_CMD_WR:  bus_addr = last_word ? OFS_LAST : OFS_CMD;
      S_FREE_RD: bus_addr = OFS_FREE;
      S_IRQ_RD:  bus_addr = OFS_IRQ;
      S_STAT_RD: bus_addr = OFS_STAT;
      S_RSP_RD:  bus_addr = OFS_RSP;
      default:   bus_addr = OFS_CMD;
    endcase
  end

  assign res_valid    = (state == S_RSP_CHK) && !in_hdr;
  assign res_data     = bus_rdata;
  assign res_last     = res_valid && (rsp_left == LEN_W'(1));
  assign done         = (state == S_DONE);
  assign done_err     = err_q;
  assign done_count   = cnt_q;
  assign done_timeout = tmo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      hdr_q      <= '0;
      words_left <= '0;
      hdr_sent   <= 1'b0;
      in_hdr     <= 1'b0;
      rsp_left   <= '0;
      err_q      <= '0;
      cnt_q      <= '0;
      tmo_q      <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          hdr_q      <= req_header;
          words_left <= WL_W'(req_argc) + 1'b1;
          hdr_sent   <= 1'b0;
          err_q      <= '0;
          cnt_q      <= '0;
          tmo_q      <= 1'b0;
          state      <= S_FREE_RD;
        end
        S_FREE_RD: state <= S_FREE_CHK;
        S_FREE_CHK: begin
          if (free_ok)           state <= S_CMD_WR;
          else if (poll_expired) begin tmo_q <= 1'b1; state <= S_DONE; end
          else                   state <= S_FREE_RD;
        end
        S_CMD_WR: if (cmd_have) begin
          hdr_sent   <= 1'b1;
          words_left <= words_left - 1'b1;
          state      <= last_word ? S_IRQ_RD : S_SETTLE;
        end
        S_SETTLE: if (settle_zero) state <= S_FREE_RD;
        S_IRQ_RD: state <= S_IRQ_CHK;
        S_IRQ_CHK: begin
          if (irq_ok) begin in_hdr <= 1'b1; state <= S_STAT_RD; end
          else if (poll_expired) begin tmo_q <= 1'b1; state <= S_DONE; end
          else state <= S_IRQ_RD;
        end
        S_STAT_RD: state <= S_STAT_CHK;
        S_STAT_CHK: begin
          if (stat_ok)           state <= S_RSP_RD;
          else if (poll_expired) begin tmo_q <= 1'b1; state <= S_DONE; end
          else                   state <= S_STAT_RD;
        end
        S_RSP_RD: state <= S_RSP_CHK;
        S_RSP_CHK: begin
          if (in_hdr) begin
            in_hdr   <= 1'b0;
            err_q    <= hdr_err(bus_rdata);
            rsp_left <= hdr_len(bus_rdata);
            if (hdr_err(bus_rdata) != '0 || hdr_len(bus_rdata) == '0)
              state <= S_DONE;
            else
              state <= S_STAT_RD;
          end else begin
            cnt_q    <= cnt_q + 1'b1;
            rsp_left <= rsp_left - 1'b1;
            state    <= (rsp_left == LEN_W'(1)) ? S_DONE : S_STAT_RD;
          end
        end
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // ------------------------------------------------------------------
  // Observers built from bus traffic only, used by the assertions below
  // ------------------------------------------------------------------
  localparam int unsigned GW = $clog2(SETTLE_CYC + 1);

  logic              rd_free_q, rd_irq_q, rd_stat_q;
  logic              space_seen, irq_seen, fill_seen, wr_seen;
  logic [GW-1:0]     since_wr;
  logic [WL_W-1:0]   wr_cnt;
  logic [ARGC_W-1:0] argc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_free_q <= 1'b0; rd_irq_q <= 1'b0; rd_stat_q <= 1'b0;
      space_seen <= 1'b0; irq_seen <= 1'b0; fill_seen <= 1'b0;
      wr_seen <= 1'b0; since_wr <= '0; wr_cnt <= '0; argc_q <= '0;
    end else begin
      rd_free_q <= bus_read && (bus_addr == OFS_FREE);
      rd_irq_q  <= bus_read && (bus_addr == OFS_IRQ);
      rd_stat_q <= bus_read && (bus_addr == OFS_STAT);

      if (bus_write)                          space_seen <= 1'b0;
      else if (rd_free_q && bus_rdata != '0)  space_seen <= 1'b1;

      if (req_valid && req_ready)             irq_seen <= 1'b0;
      else if (rd_irq_q && bus_rdata[0])      irq_seen <= 1'b1;

      if (bus_read && bus_addr == OFS_RSP)    fill_seen <= 1'b0;
      else if (rd_stat_q)                     fill_seen <= (stat_fill(bus_rdata) != '0);

      if (req_valid && req_ready) begin
        wr_seen <= 1'b0; wr_cnt <= '0; argc_q <= req_argc;
      end else if (bus_write) begin
        wr_seen <= 1'b1; wr_cnt <= wr_cnt + 1'b1;
      end

      if (bus_write)                          since_wr <= '0;
      else if (since_wr != GW'(SETTLE_CYC))   since_wr <= since_wr + 1'b1;
    end
  end

  // R1
  space_before_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_write |-> space_seen);

  // R2
  settle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_read && bus_addr == OFS_FREE && wr_seen) |-> (since_wr >= GW'(SETTLE_CYC)));

  // R3
  last_word_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_write && bus_addr == OFS_LAST) |-> (wr_cnt == WL_W'(argc_q)));

  // R3
  nothing_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_write && bus_addr == OFS_LAST) |=> !bus_write);

  // R4
  irq_before_response_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_read && (bus_addr == OFS_RSP || bus_addr == OFS_STAT)) |-> irq_seen);

  // R7
  fill_before_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_read && bus_addr == OFS_RSP) |-> fill_seen);

  // R6
  error_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && done_err != '0) |-> (done_count == '0));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: tb/mbx_txn_seq_test.sv
module mbx_txn_seq_test;
  localparam int POLL = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_header = '0;
  logic [3:0]  req_argc = '0;
  logic        arg_valid = 1'b0;
  logic        arg_ready;
  logic [31:0] arg_data = '0;
  logic [3:0]  bus_addr;
  logic        bus_write;
  logic [31:0] bus_wdata;
  logic        bus_read;
  logic [31:0] bus_rdata = '0;
  logic        res_valid, res_last, done, done_timeout, busy;
  logic [31:0] res_data;
  logic [10:0] done_err, done_count;

  always #10 clk = ~clk;

  mbx_txn_seq #(.ARGC_W(4), .POLL_LIMIT(POLL), .SETTLE_CYC(3)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_header(req_header), .req_argc(req_argc),
    .arg_valid(arg_valid), .arg_ready(arg_ready), .arg_data(arg_data),
    .bus_addr(bus_addr), .bus_write(bus_write), .bus_wdata(bus_wdata),
    .bus_read(bus_read), .bus_rdata(bus_rdata),
    .res_valid(res_valid), .res_data(res_data), .res_last(res_last),
    .done(done), .done_err(done_err), .done_count(done_count),
    .done_timeout(done_timeout), .busy(busy)
  );

  int total = 0;
  int fails = 0;

  task automatic check(input bit ok, input string rq, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, exp);
    end
  endtask

  // ---------------- mailbox model ----------------
  logic [31:0] fs_val = 32'd8;
  logic        irq_bit = 1'b0;
  logic        eop_flag = 1'b1;
  logic [31:0] rsp_mem [0:16];
  int rsp_total = 0, rsp_avail = 0, rsp_idx = 0;
  int bad_reads = 0, early_last = 0, pre_irq = 0, irq_reads = 0;
  logic [3:0]  wr_a [0:31];
  logic [31:0] wr_d [0:31];
  int wr_n = 0;
  int since = 99, min_gap = 99;
  bit wseen = 0;

  always @(posedge clk) begin
    int fillv;
    fillv = rsp_avail - rsp_idx;
    if (bus_read && bus_addr == 4'd2 && wseen && since < min_gap) min_gap = since;
    if (bus_write) begin
      if (wr_n < 32) begin wr_a[wr_n] = bus_addr; wr_d[wr_n] = bus_wdata; end
      wr_n++;
      since = 0; wseen = 1;
    end else if (since < 99) since++;
    if (bus_read) begin
      if ((bus_addr == 4'd5 || bus_addr == 4'd6) && !irq_bit) pre_irq++;
      case (bus_addr)
        4'd2: bus_rdata <= fs_val;
        4'd8: begin bus_rdata <= {31'b0, irq_bit}; irq_reads++; end
        4'd6: bus_rdata <= {19'b0, 11'(fillv),
                            eop_flag && (rsp_avail == rsp_total) && (fillv > 0),
                            (rsp_idx == 0) && (fillv > 0)};
        4'd5: begin
          if (fillv <= 0) begin bad_reads++; bus_rdata <= 32'hDEAD_BEEF; end
          else begin
            if (rsp_idx == rsp_total - 1 && !eop_flag) early_last++;
            bus_rdata <= rsp_mem[rsp_idx];
            rsp_idx++;
          end
        end
        default: bus_rdata <= '0;
      endcase
    end
  end

  // ---------------- argument feeder ----------------
  logic [31:0] argv [0:15];
  int argn = 0, arg_idx = 0;
  always @(negedge clk) begin
    arg_valid = (arg_idx < argn);
    arg_data  = argv[(arg_idx < 16) ? arg_idx : 0];
  end
  always @(posedge clk) if (arg_valid && arg_ready) arg_idx <= arg_idx + 1;

  // ---------------- result collector ----------------
  logic [31:0] res_d [0:16];
  logic        res_l [0:16];
  int res_n = 0;
  always @(negedge clk) if (res_valid) begin
    if (res_n < 17) begin res_d[res_n] = res_data; res_l[res_n] = res_last; end
    res_n++;
  end

  // ---------------- one transaction ----------------
  task automatic run_txn(input logic [31:0] hdr, input int argc, input int rlen,
                         input logic [10:0] err, input int fs_zero, input int irq_at,
                         input int trickle, input int eop_late, input bit exp_tmo,
                         input string tag);
    int cyc, first_wr, all_cyc, rdy_bad, exp_words;
    bit got;
    logic [10:0] g_err, g_cnt;
    logic g_tmo;
    for (int i = 0; i < 16; i++) argv[i] = hdr ^ (32'h0101_0000 * (i + 1));
    rsp_mem[0] = (32'(rlen) << 12) | 32'(err);
    for (int i = 0; i < 16; i++) rsp_mem[i+1] = 32'hD000_0000 + (hdr[7:0] << 8) + 32'(i);
    rsp_total = (err != 0) ? 1 : 1 + rlen;
    rsp_avail = (trickle > 0) ? 0 : rsp_total;
    rsp_idx = 0; eop_flag = (eop_late == 0); irq_bit = 1'b0;
    fs_val = (fs_zero > 0) ? 32'd0 : 32'd8;
    bad_reads = 0; early_last = 0; pre_irq = 0; irq_reads = 0;
    wr_n = 0; wseen = 0; min_gap = 99; res_n = 0;
    argn = argc; arg_idx = 0;
    @(negedge clk);
    req_header = hdr; req_argc = 4'(argc); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 0; got = 0; first_wr = -1; all_cyc = -1; rdy_bad = 0;
    g_err = '0; g_cnt = '0; g_tmo = 1'b0;
    while (!got && cyc < 4000) begin
      if (fs_zero > 0 && cyc == fs_zero) fs_val = 32'd8;
      if (bus_write && first_wr < 0) first_wr = cyc;
      if (irq_at >= 0 && cyc >= irq_at) irq_bit = 1'b1;
      if (trickle > 0 && irq_bit && (cyc % trickle) == 0 && rsp_avail < rsp_total) rsp_avail++;
      if (!eop_flag && rsp_avail == rsp_total && all_cyc < 0) all_cyc = cyc;
      if (!eop_flag && all_cyc >= 0 && cyc >= all_cyc + eop_late) eop_flag = 1'b1;
      if (busy && req_ready) rdy_bad++;
      if (done) begin got = 1; g_err = done_err; g_cnt = done_count; g_tmo = done_timeout; end
      @(negedge clk);
      cyc++;
    end
    check(got, {tag, " R9 done seen"}, 32'(got), 1);
    // R9: single-cycle pulse, sampled one cycle after it was seen
    check(!done, {tag, " R9 done one cycle"}, 32'(done), 0);
    check(rdy_bad == 0, {tag, " R8 req_ready low while busy"}, 32'(rdy_bad), 0);
    check(!busy && req_ready, {tag, " R8 idle after done"}, 32'(busy), 0);
    check(g_tmo == exp_tmo, {tag, " R10 timeout flag"}, 32'(g_tmo), 32'(exp_tmo));
    check(pre_irq == 0, {tag, " R4 no response access before irq"}, 32'(pre_irq), 0);
    check(bad_reads == 0, {tag, " R5 R7 no read of empty FIFO"}, 32'(bad_reads), 0);
    check(early_last == 0, {tag, " R7 final word only after EOP"}, 32'(early_last), 0);
    if (argc > 0) check(min_gap >= 3, {tag, " R2 settle gap"}, 32'(min_gap), 3);
    if (fs_zero > 0) check(first_wr > fs_zero, {tag, " R1 no write while full"},
                           32'(first_wr), 32'(fs_zero + 1));
    if (!exp_tmo) begin
      exp_words = (err != 0) ? 0 : rlen;
      check(wr_n == argc + 1, {tag, " R3 command word count"}, 32'(wr_n), 32'(argc + 1));
      for (int i = 0; i <= argc && i < 32; i++) begin
        check(wr_a[i] == ((i == argc) ? 4'd1 : 4'd0), {tag, " R3 write offset"},
              32'(wr_a[i]), (i == argc) ? 1 : 0);
        check(wr_d[i] == ((i == 0) ? hdr : argv[i-1]), {tag, " R3 write data"},
              wr_d[i], (i == 0) ? hdr : argv[i-1]);
      end
      check(g_err == err, {tag, " R6 done_err"}, 32'(g_err), 32'(err));
      check(g_cnt == 11'(exp_words), {tag, " R9 done_count"}, 32'(g_cnt), 32'(exp_words));
      check(res_n == exp_words, {tag, " R7 result words"}, 32'(res_n), 32'(exp_words));
      for (int i = 0; i < exp_words && i < res_n; i++) begin
        check(res_d[i] == rsp_mem[i+1], {tag, " R7 result data"}, res_d[i], rsp_mem[i+1]);
        check(res_l[i] == (i == exp_words - 1), {tag, " R7 res_last"},
              32'(res_l[i]), 32'(i == exp_words - 1));
      end
      if (err != 0) check(rsp_idx == 1, {tag, " R6 data phase skipped"}, 32'(rsp_idx), 1);
    end else begin
      check(irq_reads == POLL, {tag, " R10 poll count before abort"}, 32'(irq_reads), POLL);
      for (int i = 0; i < 4; i++) begin
        check(!bus_read && !bus_write, {tag, " R10 bus quiet after abort"},
              32'({bus_read, bus_write}), 0);
        @(negedge clk);
      end
    end
  endtask

  task automatic t_reset;
    // R11
    check(!busy, "R11 busy after reset", 32'(busy), 0);
    check(req_ready, "R11 req_ready after reset", 32'(req_ready), 1);
    check(!bus_write && !bus_read, "R11 bus idle after reset", 32'({bus_write, bus_read}), 0);
    check(!done && !res_valid, "R11 outputs idle after reset", 32'({done, res_valid}), 0);
  endtask

  initial begin
    #(20 * 150000);
    fails++; total++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    run_txn(32'hA500_0011, 0, 0, 11'd0,    0,  0, 0,  0, 1'b0, "noarg");
    run_txn(32'h1234_0042, 3, 4, 11'd0,    0,  0, 0,  0, 1'b0, "args3");
    run_txn(32'h7700_0003, 2, 2, 11'd0,   30,  0, 0,  0, 1'b0, "stall");
    run_txn(32'h3C00_0005, 1, 5, 11'd0,    0, 30, 7, 20, 1'b0, "trickle");
    run_txn(32'h5100_0009, 1, 3, 11'h02A,  0,  5, 0,  0, 1'b0, "error");
    run_txn(32'h6600_0001, 0, 0, 11'd0,    0, -1, 0,  0, 1'b1, "timeout");
    run_txn(32'h0F00_00C7, 15, 6, 11'd0,   0, 10, 0,  0, 1'b0, "maxargs");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule